// File: doc/BRIEF.md
# LIN Sync Field Edge Timer

This block measures how long the bus master takes to send a known stretch of the LIN sync field. It is used to recover the master's baud rate. A sampled copy of the bus line is fed through a small synchronizer and an edge detector. After an external break detector reports a valid break, the block counts bus edges. The falling edge that opened the break is taken as edge one. A 16-bit timer advances on a fixed-rate tick enable, which does not depend on the system clock or the baud rate.

Two 4-bit fields in one configuration byte set the measurement window:
- The start field, in bits 3:0, names the falling edge on which the timer is cleared and begins to count.
- The stop field, in bits 7:4, names the edge on which the timer freezes. A separate select input chooses whether the stop edge is a rising or a falling edge.

When the timer stops, the count is held on the read port and a done flag is raised. Software then divides by the number of bit times in the window to get the baud divisor. If the stop edge never arrives, the timer saturates at all ones and an overflow flag is raised instead. Both flags clear on the next arm pulse.

Top module: `lin_sync_timer`

## Requirements
- R1: After reset the configuration byte reads 0x32 (stop field 3 in bits 7:4, start field 2 in bits 3:0), the count reads 0, and done and overflow are both 0.
- R2: A cycle with the configuration write strobe high loads the write data, and the configuration read port shows the new value from the next cycle on.
- R3: Without an arm pulse since reset or since the last finished measurement, bus edges and ticks leave the count, done and overflow unchanged.
- R4: An arm pulse clears the count, done and overflow in the next cycle. It also takes the break's opening falling edge as falling edge number 1, so the first later falling edge is number 2.
- R5: The bus input passes two synchronizing flops plus one edge register. An edge acts on the third rising clock edge after the new level is first sampled. On the falling edge whose number equals the start field, the count is cleared to 0 and counting begins. While counting, each cycle with the tick input high adds 1.
- R6: While counting, the edge whose number equals the stop field freezes the count and sets done. This is a rising edge when the stop-select input is 1 and a falling edge when it is 0. Rising edges are numbered from 1 after the arm pulse.
- R7: A start field of 0 or 1 makes counting begin in the cycle of the arm pulse itself.
- R8: If the count reaches 0xFFFF before the stop edge, it stays at 0xFFFF, overflow is set and done stays 0.
- R9: After done or overflow is set, further edges and ticks leave the count unchanged until the next arm pulse.
- R10: A stop edge seen before counting has begun is ignored and does not set done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Fixed-rate timer tick enable, one cycle wide |
| lin_rx_i | input | 1 | Received LIN bus level (1 = recessive) |
| break_ok_i | input | 1 | Valid-break pulse from the break detector; arms a measurement |
| stop_rise_i | input | 1 | Stop edge type: 1 = rising, 0 = falling |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data (stop field 7:4, start field 3:0) |
| cfg_o | output | 8 | Configuration read-back |
| count_o | output | 16 | Timer value; held after stop or overflow |
| done_o | output | 1 | Measurement finished on the stop edge |
| ovf_o | output | 1 | Timer saturated before the stop edge |

## Verification
A wrong edge number, whether off by one at arm time or counted from the wrong polarity, moves the start or stop point by a whole bit time. The held count then differs from the reference by tens of cycles as soon as done rises, a few cycles after the stop edge. A stuck run state shows within one tick: the count keeps moving after done, or it never moves after the start edge. The bench's cycle reference model, compared on every clock, catches this at the first cycle it differs. The saturation path is driven to the end, so a wrapped counter or a missing overflow flag shows exactly at count 0xFFFF.

// File: rtl/lin_sync_pkg.sv
package lin_sync_pkg;
  localparam int EDGE_W = 4;

  typedef struct packed {
    logic [EDGE_W-1:0] stop_n;
    logic [EDGE_W-1:0] start_n;
  } cfg_t;

  localparam cfg_t CFG_RST = '{stop_n: 4'd3, start_n: 4'd2};
endpackage

// File: rtl/lin_edge_det.sv
module lin_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q[0] <= rx_i;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = prev_q & ~sync_q[SYNC_STAGES-1];
  assign rise_o = ~prev_q & sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/lin_edge_seq.sv
module lin_edge_seq #(
  parameter int EDGE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              arm_i,
  input  logic              fall_i,
  input  logic              rise_i,
  input  logic [EDGE_W-1:0] start_n_i,
  input  logic [EDGE_W-1:0] stop_n_i,
  input  logic              stop_rise_i,
  input  logic              run_i,
  input  logic              sat_i,
  output logic              start_hit_o,
  output logic              stop_hit_o
);
  localparam logic [EDGE_W-1:0] ONE = 1;

  logic [EDGE_W-1:0] fall_cnt_q, rise_cnt_q, fall_nx, rise_nx;
  logic              armed_q, live;

  // edge numbers saturate at the field maximum
  assign fall_nx = (fall_i && fall_cnt_q != '1) ? fall_cnt_q + ONE : fall_cnt_q;
  assign rise_nx = (rise_i && rise_cnt_q != '1) ? rise_cnt_q + ONE : rise_cnt_q;
  assign live    = armed_q & ~arm_i;

  assign start_hit_o = live & ~run_i & fall_i & (fall_nx == start_n_i);
  assign stop_hit_o  = live & run_i &
                       (stop_rise_i ? (rise_i & (rise_nx == stop_n_i))
                                    : (fall_i & (fall_nx == stop_n_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fall_cnt_q <= '0;
      rise_cnt_q <= '0;
      armed_q    <= 1'b0;
    end else if (arm_i) begin
      fall_cnt_q <= ONE;  // break's own falling edge
      rise_cnt_q <= '0;
      armed_q    <= 1'b1;
    end else if (live) begin
      fall_cnt_q <= fall_nx;
      rise_cnt_q <= rise_nx;
      if (stop_hit_o || sat_i) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/lin_sync_cnt.sv
module lin_sync_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             run_at_arm_i,
  input  logic             start_hit_i,
  input  logic             stop_hit_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] ONE  = 1;
  localparam logic [CNT_W-1:0] LAST = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] cnt_q;
  logic             run_q, done_q, ovf_q;

  assign sat_o = run_q & tick_i & (cnt_q == LAST) & ~arm_i & ~start_hit_i & ~stop_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (arm_i) begin
      cnt_q  <= '0;
      run_q  <= run_at_arm_i;
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (start_hit_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (stop_hit_i) begin
      run_q  <= 1'b0;
      done_q <= 1'b1;
    end else if (sat_o) begin
      cnt_q <= '1;
      run_q <= 1'b0;
      ovf_q <= 1'b1;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q + ONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign run_o  = run_q;
  assign done_o = done_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/lin_sync_timer.sv
module lin_sync_timer
  import lin_sync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lin_rx_i,
  input  logic             break_ok_i,
  input  logic             stop_rise_i,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_wdata_i,
  output logic [7:0]       cfg_o,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             ovf_o
);
  localparam logic [EDGE_W-1:0] ARM_START_MAX = 1;

  cfg_t cfg_q;
  logic fall, rise, start_hit, stop_hit, run, sat, run_at_arm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= CFG_RST;
    else if (cfg_we_i) cfg_q <= cfg_t'(cfg_wdata_i);
  end

  assign cfg_o      = cfg_q;
  assign run_at_arm = cfg_q.start_n <= ARM_START_MAX;

  lin_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rx_i  (lin_rx_i),
    .fall_o(fall),
    .rise_o(rise)
  );

  lin_edge_seq #(.EDGE_W(EDGE_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (break_ok_i),
    .fall_i     (fall),
    .rise_i     (rise),
    .start_n_i  (cfg_q.start_n),
    .stop_n_i   (cfg_q.stop_n),
    .stop_rise_i(stop_rise_i),
    .run_i      (run),
    .sat_i      (sat),
    .start_hit_o(start_hit),
    .stop_hit_o (stop_hit)
  );

  lin_sync_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (break_ok_i),
    .run_at_arm_i(run_at_arm),
    .start_hit_i (start_hit),
    .stop_hit_i  (stop_hit),
    .tick_i      (tick_i),
    .cnt_o       (count_o),
    .run_o       (run),
    .done_o      (done_o),
    .ovf_o       (ovf_o),
    .sat_o       (sat)
  );
endmodule

// File: rtl/lin_sync_timer_chk.sv
module lin_sync_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             break_ok_i,
  input logic             cfg_we_i,
  input logic [7:0]       cfg_wdata_i,
  input logic [7:0]       cfg_o,
  input logic [CNT_W-1:0] count_o,
  input logic             done_o,
  input logic             ovf_o
);
  localparam logic [CNT_W-1:0] ONE = 1;

  a_r2_cfg_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> cfg_o == $past(cfg_wdata_i));

  a_r4_arm_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_ok_i |=> (!done_o && !ovf_o && count_o == '0));

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o != $past(count_o) && count_o != '0) |->
      ($past(tick_i) && count_o == $past(count_o) + ONE));

  a_r8_ovf_saturated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (count_o == '1 && !done_o));

  a_r9_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !break_ok_i) |=> ($stable(count_o) && done_o));

  a_r9_ovf_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !break_ok_i) |=> ($stable(count_o) && ovf_o));
endmodule

bind lin_sync_timer lin_sync_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .break_ok_i (break_ok_i),
  .cfg_we_i   (cfg_we_i),
  .cfg_wdata_i(cfg_wdata_i),
  .cfg_o      (cfg_o),
  .count_o    (count_o),
  .done_o     (done_o),
  .ovf_o      (ovf_o)
);

// File: tb/tb_lin_sync_timer.sv
`timescale 1ns/1ps
module tb_lin_sync_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        b_tick = 1'b0, b_lin = 1'b1, b_arm = 1'b0, b_srise = 1'b0, b_we = 1'b0;
  logic [7:0]  b_wd = 8'h00;
  logic [7:0]  cfg_o;
  logic [15:0] count_o;
  logic        done_o, ovf_o;

  int checks = 0, errors = 0, cyc = 0, tick_per = 1, tick_div = 0;
  bit cmp_en = 0;
  string cur_req = "R1";

  always #2 clk_i = ~clk_i;

  lin_sync_timer dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(b_tick), .lin_rx_i(b_lin),
    .break_ok_i(b_arm), .stop_rise_i(b_srise), .cfg_we_i(b_we), .cfg_wdata_i(b_wd),
    .cfg_o(cfg_o), .count_o(count_o), .done_o(done_o), .ovf_o(ovf_o)
  );

  // behavioural reference
  int m_fall = 0, m_rise = 0, m_cnt = 0;
  bit m_armed = 0, m_run = 0, m_done = 0, m_ovf = 0;
  bit [7:0] m_cfg = 8'h32;
  bit hist[$] = '{1'b1, 1'b1, 1'b1};

  always @(posedge clk_i) begin
    bit f, r, ph, sh;
    int nf, nr, st, sp;
    if (!rst_ni) begin
      m_fall = 0; m_rise = 0; m_cnt = 0; m_armed = 0; m_run = 0;
      m_done = 0; m_ovf = 0; m_cfg = 8'h32; hist = '{1'b1, 1'b1, 1'b1};
    end else begin
      f = hist[0] && !hist[1];
      r = !hist[0] && hist[1];
      st = int'(m_cfg[3:0]);
      sp = int'(m_cfg[7:4]);
      if (b_arm) begin
        m_fall = 1; m_rise = 0; m_armed = 1; m_done = 0; m_ovf = 0; m_cnt = 0;
        m_run = (st < 2);
      end else if (m_armed) begin
        nf = (f && m_fall < 15) ? m_fall + 1 : m_fall;
        nr = (r && m_rise < 15) ? m_rise + 1 : m_rise;
        ph = f && !m_run && nf == st;
        sh = m_run && (b_srise ? (r && nr == sp) : (f && nf == sp));
        m_fall = nf; m_rise = nr;
        if (ph) begin m_cnt = 0; m_run = 1; end
        else if (sh) begin m_run = 0; m_done = 1; m_armed = 0; end
        else if (m_run && b_tick) begin
          if (m_cnt == 65534) begin m_cnt = 65535; m_run = 0; m_ovf = 1; m_armed = 0; end
          else m_cnt++;
        end
      end
      if (b_we) m_cfg = b_wd;
      hist.push_back(b_lin);
      void'(hist.pop_front());
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_en) begin
      check(count_o == m_cnt[15:0], cur_req, "model count", count_o, m_cnt);
      check(done_o == m_done, cur_req, "model done", done_o, m_done);
      check(ovf_o == m_ovf, cur_req, "model ovf", ovf_o, m_ovf);
      check(cfg_o == m_cfg, cur_req, "model cfg", cfg_o, m_cfg);
    end
  end

  always @(negedge clk_i) begin
    if (tick_per <= 1) b_tick <= 1'b1;
    else begin
      tick_div = (tick_div + 1) % tick_per;
      b_tick <= (tick_div == 0);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 190000) begin
      errors++;
      $display("FAIL watchdog cycles=%0d limit=%0d", cyc, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic arm();
    b_arm = 1'b1; step(1); b_arm = 1'b0;
  endtask

  task automatic wcfg(logic [7:0] v);
    b_we = 1'b1; b_wd = v; step(1); b_we = 1'b0;
  endtask

  task automatic lin_to(logic v, int hold);
    b_lin = v; step(hold);
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1);
    cmp_en = 1;
    // R1 reset state
    check(cfg_o == 8'h32, "R1", "cfg reset", cfg_o, 8'h32);
    check(count_o == 0 && !done_o && !ovf_o, "R1", "idle outputs", count_o, 0);

    // R2 config write
    cur_req = "R2";
    wcfg(8'hA5);
    check(cfg_o == 8'hA5, "R2", "cfg readback", cfg_o, 8'hA5);
    wcfg(8'h32);

    // R3 edges without arm
    cur_req = "R3";
    for (int i = 0; i < 6; i++) begin lin_to(1'b0, 7); lin_to(1'b1, 9); end
    check(count_o == 0 && !done_o, "R3", "unarmed count", count_o, 0);

    // R4 R5 R6 default window: fall 2 to fall 3, distance 30 cycles
    cur_req = "R6";
    lin_to(1'b0, 5);
    arm();
    step(5);
    lin_to(1'b1, 6);
    lin_to(1'b0, 20);
    lin_to(1'b1, 10);
    lin_to(1'b0, 8);
    check(done_o == 1'b1, "R6", "done after fall stop", done_o, 1);
    check(count_o == 29, "R5", "count start fall2 to fall3", count_o, 29);

    // R9 no change after done
    cur_req = "R9";
    for (int i = 0; i < 4; i++) begin lin_to(1'b1, 6); lin_to(1'b0, 6); end
    check(count_o == 29, "R9", "held after done", count_o, 29);
    lin_to(1'b1, 10);

    // R6 rising stop, stop 2 start 2
    cur_req = "R6";
    wcfg(8'h22);
    b_srise = 1'b1;
    lin_to(1'b0, 5);
    arm();
    step(4);
    lin_to(1'b1, 6);
    lin_to(1'b0, 12);
    lin_to(1'b1, 8);
    check(done_o == 1'b1, "R6", "done after rise stop", done_o, 1);
    check(count_o == 11, "R6", "count fall2 to rise2", count_o, 11);
    b_srise = 1'b0;

    // R4 arm clears
    cur_req = "R4";
    arm();
    check(!done_o && count_o == 0, "R4", "cleared by arm", done_o, 0);

    // R5 divided tick, default window
    cur_req = "R5";
    wcfg(8'h32);
    tick_per = 4;
    lin_to(1'b0, 5);
    arm();
    step(3);
    lin_to(1'b1, 6);
    lin_to(1'b0, 24);
    lin_to(1'b1, 16);
    lin_to(1'b0, 8);
    check(done_o == 1'b1, "R5", "done with slow tick", done_o, 1);
    check(count_o >= 8 && count_o <= 11, "R5", "slow tick count range", count_o, 10);
    tick_per = 1;
    lin_to(1'b1, 10);

    // R10 stop before start ignored (start 4, stop 3)
    cur_req = "R10";
    wcfg(8'h34);
    lin_to(1'b0, 5);
    arm();
    lin_to(1'b1, 5);
    lin_to(1'b0, 5);
    lin_to(1'b1, 5);
    lin_to(1'b0, 5);
    lin_to(1'b1, 5);
    lin_to(1'b0, 10);
    lin_to(1'b1, 5);
    lin_to(1'b0, 10);
    check(done_o == 1'b0, "R10", "early stop ignored", done_o, 0);
    check(count_o != 0, "R10", "still counting", count_o, 1);
    lin_to(1'b1, 5);

    // R7 start at arm, R8 saturation
    cur_req = "R7";
    wcfg(8'h30);
    arm();
    step(10);
    check(count_o == 10, "R7", "counting from arm", count_o, 10);
    cur_req = "R8";
    step(65540);
    check(ovf_o == 1'b1 && done_o == 1'b0, "R8", "overflow flag", ovf_o, 1);
    check(count_o == 16'hFFFF, "R8", "saturated count", count_o, 16'hFFFF);
    cur_req = "R9";
    for (int i = 0; i < 3; i++) begin lin_to(1'b0, 6); lin_to(1'b1, 6); end
    check(count_o == 16'hFFFF && ovf_o, "R9", "held after overflow", count_o, 16'hFFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule